// File: doc/BRIEF.md
# Transmit Packet Loader with Permit Gating

This block sits between a host and a byte-level SPI transaction master in front of a sub-GHz radio transceiver. The host hands it one command at a time. There are four commands: select a channel, set the output power, load a packet, and send the loaded packet. The block turns each command into one or two serial transactions on the radio's register interface. It drives these as a byte stream, with start and end markers for each transaction, and finishes each command with a one-cycle response carrying a status code.

A single transmit-permit flag guards the radio. Selecting a channel outside a configured window revokes the permit, and so does setting the power to zero. Selecting an in-range channel restores the permit, and so does setting a nonzero power. While the permit is revoked, load and send commands are refused without touching the radio. The requested power is clamped to a maximum and written to the front-end transmit register as (power − 1) OR a configured base value. A load writes a length byte, capped at 61, followed by that many payload bytes, all in one burst write to the FIFO address. A send issues the transmit strobe and waits for the falling edge of the radio's end-of-packet pin. If that edge does not arrive within a configured number of cycles, the block issues the idle strobe and reports a timeout.

Top module: `txpkt_loader`

## Requirements
- R1: After reset, cmd_ready is 1, rx_only is 1, spi_valid is 0 and rsp_valid is 0.
- R2: A channel command (cmd_op 0) sets rx_only to 1 when cmd_arg lies outside [CHAN_MIN, CHAN_MAX] and clears it when inside. In both cases it emits one transaction of two bytes: 0x0A (start marker), then the channel (end marker). The response is OK.
- R3: A power command (cmd_op 1) with a nonzero argument first clamps the argument p to PWR_MAX. It then clears rx_only and emits one transaction: 0x22 (start marker), then (p − 1) OR FRONT_BASE (end marker). The response is OK.
- R4: A power command with argument 0 sets rx_only to 1, emits no SPI byte, and responds OK on the cycle after acceptance.
- R5: A load command (cmd_op 2) with size s emits one transaction. It starts with 0x7F (start marker), followed by L = min(s, 61). It then takes exactly L bytes from the payload stream and passes them on in order. The end marker sits on the last byte sent, which is the length byte itself when L is 0. The response is OK.
- R6: While rx_only is 1, a load or send command is refused. The block responds DENIED on the cycle after acceptance, emits no SPI byte and takes no payload byte.
- R7: A send command (cmd_op 3) while rx_only is 0 emits the single-byte transaction 0x35 (start and end marker). It then waits for a falling edge on eop_pin and responds OK.
- R8: If no falling edge of eop_pin is seen within TIMEOUT_CYC cycles of waiting, the block emits the single-byte transaction 0x36 and responds TIMEOUT.
- R9: Only one command is in flight. cmd_ready drops on the cycle after acceptance and returns only after the response. No SPI byte is offered while cmd_ready is 1.
- R10: rsp_valid is a one-cycle pulse. rsp_status encodes OK = 0, DENIED = 1, TIMEOUT = 2.
- R11: While spi_valid is 1 and spi_ready is 0, spi_valid, spi_data, spi_first and spi_last hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host command offered |
| cmd_ready | output | 1 | Block idle, command accepted when both high |
| cmd_op | input | 2 | 0 channel, 1 power, 2 load, 3 send |
| cmd_arg | input | 8 | Channel, power level or payload size |
| pay_valid | input | 1 | Payload byte offered |
| pay_ready | output | 1 | Payload byte taken when both high |
| pay_data | input | 8 | Payload byte |
| spi_valid | output | 1 | Byte offered to the SPI transaction master |
| spi_ready | input | 1 | SPI master takes the byte |
| spi_data | output | 8 | Byte to shift out |
| spi_first | output | 1 | Byte opens a transaction (select asserted) |
| spi_last | output | 1 | Byte closes a transaction (select released) |
| eop_pin | input | 1 | Radio sync/end-of-packet pin, asynchronous |
| rsp_valid | output | 1 | Command complete, one-cycle pulse |
| rsp_status | output | 2 | Completion code |
| rx_only | output | 1 | Transmit permit revoked |

## Verification
The hardest situation to reach from the ports is the expiry of the end-of-packet wait. It needs a send that passes the permit check, followed by a pin that never falls, and it must be separated from the normal case, where the edge arrives only after strobe back-pressure and synchronizer delay. The bench shortens the timeout through the parameter. It then mixes random sends that either pulse the pin a fixed number of cycles after the strobe byte is seen, or leave it low, so both branches run while the SPI ready signal stalls at random. Random sequences of channel and power commands keep flipping the permit, so that refused loads and sends land between granted ones.

// File: rtl/txpkt_pkg.sv
package txpkt_pkg;

    typedef enum logic [1:0] {
        OP_CHAN  = 2'd0,
        OP_POWER = 2'd1,
        OP_LOAD  = 2'd2,
        OP_SEND  = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        ST_OK      = 2'd0,
        ST_DENIED  = 2'd1,
        ST_TIMEOUT = 2'd2
    } rsp_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_REG_HDR,
        S_REG_DATA,
        S_LD_HDR,
        S_LD_LEN,
        S_LD_PAY,
        S_STRB_TX,
        S_WAIT_EOP,
        S_STRB_IDLE,
        S_RESP
    } state_e;

    // Radio register map entries the loader touches
    localparam logic [7:0] A_CHAN     = 8'h0A;
    localparam logic [7:0] A_FRONT_TX = 8'h22;
    localparam logic [7:0] A_FIFO     = 8'h3F;
    localparam logic [7:0] BURST_WR   = 8'h40;
    localparam logic [7:0] CMD_TX     = 8'h35;
    localparam logic [7:0] CMD_IDLE   = 8'h36;

    typedef struct packed {
        logic       valid;
        logic       first;
        logic       last;
        logic [7:0] data;
    } spi_beat_t;

    function automatic logic [7:0] cap_len(input logic [7:0] size, input logic [7:0] lim);
        return (size > lim) ? lim : size;
    endfunction

    function automatic logic [7:0] pwr_field(input logic [7:0] lvl, input logic [7:0] base);
        return (lvl - 8'd1) | base;
    endfunction

endpackage

// File: rtl/txpkt_gate.sv
module txpkt_gate
    import txpkt_pkg::*;
#(
    parameter int         CHAN_MIN   = 1,
    parameter int         CHAN_MAX   = 40,
    parameter int         PWR_MAX    = 10,
    parameter logic [7:0] FRONT_BASE = 8'hC0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       chan_we,
    input  logic       pwr_we,
    input  logic [7:0] arg,
    output logic       rx_only,
    output logic       pwr_zero,
    output logic [7:0] pwr_code
);
    localparam logic [7:0] LO  = 8'(CHAN_MIN);
    localparam logic [7:0] HI  = 8'(CHAN_MAX);
    localparam logic [7:0] PMX = 8'(PWR_MAX);

    logic [7:0] lvl;
    logic       chan_ok;

    always_comb begin
        lvl      = (arg > PMX) ? PMX : arg;
        pwr_zero = (lvl == 8'd0);
        pwr_code = pwr_field(lvl, FRONT_BASE);
        chan_ok  = (arg >= LO) && (arg <= HI);
    end

    always_ff @(posedge clk) begin
        if (rst)
            rx_only <= 1'b1;
        else if (chan_we)
            rx_only <= !chan_ok;
        else if (pwr_we)
            rx_only <= pwr_zero;
    end
endmodule

// File: rtl/txpkt_eop_watch.sv
module txpkt_eop_watch #(
    parameter int SYNC_STAGES = 2,
    parameter int TIMEOUT_CYC = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic pin,
    output logic fall,
    output logic expired
);
    localparam int CW = $clog2(TIMEOUT_CYC + 1);

    logic [SYNC_STAGES:0] sh;
    logic [CW-1:0]        cnt;

    genvar g;
    generate
        for (g = 0; g <= SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk) begin
                if (rst)
                    sh[g] <= 1'b0;
                else if (g == 0)
                    sh[g] <= pin;
                else
                    sh[g] <= sh[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst || !arm)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign fall    = arm && sh[SYNC_STAGES] && !sh[SYNC_STAGES-1];
    assign expired = arm && !fall && (cnt == CW'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/txpkt_loader.sv
module txpkt_loader
    import txpkt_pkg::*;
#(
    parameter int         CHAN_MIN    = 1,
    parameter int         CHAN_MAX    = 40,
    parameter int         PWR_MAX     = 10,
    parameter logic [7:0] FRONT_BASE  = 8'hC0,
    parameter int         MAX_PAYLOAD = 61,
    parameter int         SYNC_STAGES = 2,
    parameter int         TIMEOUT_CYC = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    output logic       cmd_ready,
    input  logic [1:0] cmd_op,
    input  logic [7:0] cmd_arg,
    input  logic       pay_valid,
    output logic       pay_ready,
    input  logic [7:0] pay_data,
    output logic       spi_valid,
    input  logic       spi_ready,
    output logic [7:0] spi_data,
    output logic       spi_first,
    output logic       spi_last,
    input  logic       eop_pin,
    output logic       rsp_valid,
    output logic [1:0] rsp_status,
    output logic       rx_only
);
    localparam logic [7:0] LEN_CAP = 8'(MAX_PAYLOAD);

    state_e     state;
    rsp_e       rsp_q;
    logic [7:0] reg_addr, reg_val, len_q, cnt_q;
    spi_beat_t  beat;
    op_e        op;
    logic       acc, fire, pwr_zero, eop_fall, eop_late;
    logic [7:0] pwr_code;

    assign op        = op_e'(cmd_op);
    assign cmd_ready = (state == S_IDLE);
    assign acc       = cmd_valid && cmd_ready;

    txpkt_gate #(
        .CHAN_MIN  (CHAN_MIN),
        .CHAN_MAX  (CHAN_MAX),
        .PWR_MAX   (PWR_MAX),
        .FRONT_BASE(FRONT_BASE)
    ) u_gate (
        .clk     (clk),
        .rst     (rst),
        .chan_we (acc && op == OP_CHAN),
        .pwr_we  (acc && op == OP_POWER),
        .arg     (cmd_arg),
        .rx_only (rx_only),
        .pwr_zero(pwr_zero),
        .pwr_code(pwr_code)
    );

    txpkt_eop_watch #(
        .SYNC_STAGES(SYNC_STAGES),
        .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_watch (
        .clk    (clk),
        .rst    (rst),
        .arm    (state == S_WAIT_EOP),
        .pin    (eop_pin),
        .fall   (eop_fall),
        .expired(eop_late)
    );

    // Byte presented to the SPI transaction master in each state
    always_comb begin
        beat = '0;
        unique case (state)
            S_REG_HDR:   beat = '{valid: 1'b1, first: 1'b1, last: 1'b0, data: reg_addr};
            S_REG_DATA:  beat = '{valid: 1'b1, first: 1'b0, last: 1'b1, data: reg_val};
            S_LD_HDR:    beat = '{valid: 1'b1, first: 1'b1, last: 1'b0, data: A_FIFO | BURST_WR};
            S_LD_LEN:    beat = '{valid: 1'b1, first: 1'b0, last: (len_q == 8'd0), data: len_q};
            S_LD_PAY:    beat = '{valid: pay_valid, first: 1'b0,
                                  last: (cnt_q == len_q - 8'd1), data: pay_data};
            S_STRB_TX:   beat = '{valid: 1'b1, first: 1'b1, last: 1'b1, data: CMD_TX};
            S_STRB_IDLE: beat = '{valid: 1'b1, first: 1'b1, last: 1'b1, data: CMD_IDLE};
            default:     beat = '0;
        endcase
    end

    assign spi_valid  = beat.valid;
    assign spi_first  = beat.first;
    assign spi_last   = beat.last;
    assign spi_data   = beat.data;
    assign fire       = beat.valid && spi_ready;
    assign pay_ready  = (state == S_LD_PAY) && spi_ready;
    assign rsp_valid  = (state == S_RESP);
    assign rsp_status = rsp_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            rsp_q    <= ST_OK;
            reg_addr <= '0;
            reg_val  <= '0;
            len_q    <= '0;
            cnt_q    <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (acc) begin
                    rsp_q <= ST_OK;
                    unique case (op)
                        OP_CHAN: begin
                            reg_addr <= A_CHAN;
                            reg_val  <= cmd_arg;
                            state    <= S_REG_HDR;
                        end
                        OP_POWER: begin
                            if (pwr_zero) begin
                                state <= S_RESP;
                            end else begin
                                reg_addr <= A_FRONT_TX;
                                reg_val  <= pwr_code;
                                state    <= S_REG_HDR;
                            end
                        end
                        OP_LOAD: begin
                            if (rx_only) begin
                                rsp_q <= ST_DENIED;
                                state <= S_RESP;
                            end else begin
                                len_q <= cap_len(cmd_arg, LEN_CAP);
                                cnt_q <= '0;
                                state <= S_LD_HDR;
                            end
                        end
                        OP_SEND: begin
                            if (rx_only) begin
                                rsp_q <= ST_DENIED;
                                state <= S_RESP;
                            end else begin
                                state <= S_STRB_TX;
                            end
                        end
                        default: state <= S_IDLE;
                    endcase
                end
                S_REG_HDR:  if (fire) state <= S_REG_DATA;
                S_REG_DATA: if (fire) state <= S_RESP;
                S_LD_HDR:   if (fire) state <= S_LD_LEN;
                S_LD_LEN:   if (fire) state <= (len_q == 8'd0) ? S_RESP : S_LD_PAY;
                S_LD_PAY: if (fire) begin
                    cnt_q <= cnt_q + 8'd1;
                    if (cnt_q == len_q - 8'd1)
                        state <= S_RESP;
                end
                S_STRB_TX:  if (fire) state <= S_WAIT_EOP;
                S_WAIT_EOP: begin
                    if (eop_fall)
                        state <= S_RESP;
                    else if (eop_late)
                        state <= S_STRB_IDLE;
                end
                S_STRB_IDLE: if (fire) begin
                    rsp_q <= ST_TIMEOUT;
                    state <= S_RESP;
                end
                S_RESP:  state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/txpkt_loader_chk.sv
module txpkt_loader_chk
    import txpkt_pkg::*;
#(
    parameter int CHAN_MIN = 1,
    parameter int CHAN_MAX = 40
) (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic       cmd_ready,
    input logic [1:0] cmd_op,
    input logic [7:0] cmd_arg,
    input logic       spi_valid,
    input logic       spi_ready,
    input logic [7:0] spi_data,
    input logic       spi_first,
    input logic       spi_last,
    input logic       rsp_valid,
    input logic [1:0] rsp_status,
    input logic       rx_only
);
    logic acc;
    assign acc = cmd_valid && cmd_ready;

    p_busy_r9: assert property (@(posedge clk) disable iff (rst)
        acc |=> !cmd_ready);

    p_quiet_idle_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !spi_valid);

    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid);

    p_rsp_code_r10: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> rsp_status != 2'd3);

    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (spi_valid && !spi_ready) |=>
            (spi_valid && $stable(spi_data) && $stable(spi_first) && $stable(spi_last)));

    p_deny_r6: assert property (@(posedge clk) disable iff (rst)
        (acc && rx_only && (cmd_op == OP_LOAD || cmd_op == OP_SEND)) |=>
            (rsp_valid && rsp_status == ST_DENIED));

    p_zero_pwr_r4: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op == OP_POWER && cmd_arg == 8'd0) |=>
            (rsp_valid && rx_only && rsp_status == ST_OK));

    p_chan_range_r2: assert property (@(posedge clk) disable iff (rst)
        (acc && cmd_op == OP_CHAN) |=>
            (rx_only == !($past(cmd_arg) >= 8'(CHAN_MIN) && $past(cmd_arg) <= 8'(CHAN_MAX))));

    p_permit_r7: assert property (@(posedge clk) disable iff (rst)
        (spi_valid && spi_first && spi_last && spi_data == CMD_TX) |-> !rx_only);
endmodule

bind txpkt_loader txpkt_loader_chk #(
    .CHAN_MIN(CHAN_MIN),
    .CHAN_MAX(CHAN_MAX)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_arg   (cmd_arg),
    .spi_valid (spi_valid),
    .spi_ready (spi_ready),
    .spi_data  (spi_data),
    .spi_first (spi_first),
    .spi_last  (spi_last),
    .rsp_valid (rsp_valid),
    .rsp_status(rsp_status),
    .rx_only   (rx_only)
);

// File: tb/txpkt_loader_test.sv
`timescale 1ns/1ps
module txpkt_loader_test;
    localparam int         CMIN = 1;
    localparam int         CMAX = 40;
    localparam int         PMAX = 10;
    localparam logic [7:0] BASE = 8'hC0;
    localparam int         TMO  = 200;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0, cmd_ready;
    logic [1:0] cmd_op = 2'd0;
    logic [7:0] cmd_arg = 8'd0;
    logic       pay_valid = 1'b0, pay_ready;
    logic [7:0] pay_data = 8'd0;
    logic       spi_valid, spi_ready = 1'b0, spi_first, spi_last;
    logic [7:0] spi_data;
    logic       eop_pin = 1'b0;
    logic       rsp_valid, rx_only;
    logic [1:0] rsp_status;

    always #2.5 clk = ~clk;

    txpkt_loader #(
        .CHAN_MIN(CMIN), .CHAN_MAX(CMAX), .PWR_MAX(PMAX), .FRONT_BASE(BASE),
        .MAX_PAYLOAD(61), .SYNC_STAGES(2), .TIMEOUT_CYC(TMO)
    ) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_arg(cmd_arg), .pay_valid(pay_valid),
        .pay_ready(pay_ready), .pay_data(pay_data), .spi_valid(spi_valid),
        .spi_ready(spi_ready), .spi_data(spi_data), .spi_first(spi_first),
        .spi_last(spi_last), .eop_pin(eop_pin), .rsp_valid(rsp_valid),
        .rsp_status(rsp_status), .rx_only(rx_only)
    );

    int checks = 0, errors = 0, cycles = 0;
    logic [9:0] log_q [0:127];
    logic [9:0] exp_q [0:127];
    int n_log = 0, n_exp = 0;
    logic [7:0] pay_buf [0:255];
    int pay_idx = 0, pay_n = 0;
    bit pay_en = 0;
    bit model_rxo = 1;
    int unsigned seed = 32'd2024;

    function automatic bit in_range(input logic [7:0] c);
        return (c >= 8'(CMIN)) && (c <= 8'(CMAX));
    endfunction
    function automatic logic [7:0] clamp_pwr(input logic [7:0] p);
        return (p > 8'(PMAX)) ? 8'(PMAX) : p;
    endfunction
    function automatic logic [7:0] cap61(input logic [7:0] s);
        return (s > 8'd61) ? 8'd61 : s;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // SPI slave model, payload source and byte logger, all away from the clock edge
    always begin
        bit pxfer;
        @(negedge clk);
        if (spi_valid && spi_ready && n_log < 128) begin
            log_q[n_log] = {spi_first, spi_last, spi_data};
            n_log++;
        end
        pxfer = pay_valid && pay_ready;
        @(posedge clk);
        #1;
        cycles++;
        spi_ready = ($urandom(seed) % 10) < 7;
        seed = seed + 32'd1;
        if (pxfer) pay_idx++;
        pay_valid = pay_en && (pay_idx < pay_n);
        pay_data  = pay_buf[pay_idx[7:0]];
    end

    task automatic push(input bit f, input bit l, input logic [7:0] d);
        exp_q[n_exp] = {f, l, d};
        n_exp++;
    endtask

    task automatic issue(input logic [1:0] op, input logic [7:0] arg);
        n_log = 0; n_exp = 0;
        @(posedge clk); #1;
        cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg;
        do @(negedge clk); while (!cmd_ready);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_rsp(output logic [1:0] st);
        int n = 0;
        st = 2'd3;
        while (!rsp_valid && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (rsp_valid) st = rsp_status;
    endtask

    task automatic cmp_log(input string req);
        int bad = -1;
        for (int i = 0; i < n_exp && i < n_log; i++)
            if (bad < 0 && log_q[i] !== exp_q[i]) bad = i;
        if (n_log != n_exp)
            check(0, {req, " byte count"}, n_log, n_exp);
        else if (bad >= 0)
            check(0, {req, " byte"}, int'(log_q[bad]), int'(exp_q[bad]));
        else
            check(1, req, 0, 0);
    endtask

    task automatic do_chan(input logic [7:0] c);
        logic [1:0] st;
        issue(2'd0, c);
        push(1, 0, 8'h0A); push(0, 1, c);
        model_rxo = !in_range(c);
        wait_rsp(st);
        check(st == 2'd0, "R2 status", st, 0);
        cmp_log("R2 transaction");
        check(rx_only == model_rxo, "R2 rx_only", rx_only, model_rxo);
    endtask

    task automatic do_power(input logic [7:0] p);
        logic [1:0] st;
        logic [7:0] lv;
        lv = clamp_pwr(p);
        issue(2'd1, p);
        if (lv == 0) begin
            model_rxo = 1;
        end else begin
            push(1, 0, 8'h22); push(0, 1, (lv - 8'd1) | BASE);
            model_rxo = 0;
        end
        wait_rsp(st);
        check(st == 2'd0, lv == 0 ? "R4 status" : "R3 status", st, 0);
        cmp_log(lv == 0 ? "R4 no write" : "R3 transaction");
        check(rx_only == model_rxo, lv == 0 ? "R4 rx_only" : "R3 rx_only", rx_only, model_rxo);
    endtask

    task automatic do_load(input logic [7:0] s);
        logic [1:0] st;
        logic [7:0] len;
        bit denied;
        denied = model_rxo;
        len = cap61(s);
        for (int i = 0; i < 256; i++) pay_buf[i] = 8'($urandom(seed));
        pay_idx = 0; pay_n = s; pay_en = 1;
        issue(2'd2, s);
        if (!denied) begin
            push(1, 0, 8'h7F); push(0, len == 0, len);
            for (int i = 0; i < len; i++) push(0, i == len - 1, pay_buf[i]);
        end
        wait_rsp(st);
        if (denied) begin
            check(st == 2'd1, "R6 load status", st, 1);
            cmp_log("R6 load no bytes");
            check(pay_idx == 0, "R6 payload untouched", pay_idx, 0);
        end else begin
            check(st == 2'd0, "R5 status", st, 0);
            cmp_log("R5 burst");
            check(pay_idx == len, "R5 payload consumed", pay_idx, len);
        end
        pay_en = 0;
    endtask

    task automatic do_send(input bit pulse);
        logic [1:0] st;
        bit denied;
        int n = 0;
        denied = model_rxo;
        issue(2'd3, 8'd0);
        if (!denied) begin
            push(1, 1, 8'h35);
            if (pulse) begin
                while (n_log == 0 && n < 500) begin @(negedge clk); n++; end
                repeat (2) @(posedge clk);
                #1 eop_pin = 1'b1;
                repeat (3) @(posedge clk);
                #1 eop_pin = 1'b0;
            end else begin
                push(1, 1, 8'h36);
            end
        end
        wait_rsp(st);
        if (denied) begin
            check(st == 2'd1, "R6 send status", st, 1);
            cmp_log("R6 send no bytes");
        end else if (pulse) begin
            check(st == 2'd0, "R7 status", st, 0);
            cmp_log("R7 strobe");
        end else begin
            check(st == 2'd2, "R8 status", st, 2);
            cmp_log("R8 strobes");
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            if (cycles > 150000) begin
                checks++; errors++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                finish_run();
            end
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(cmd_ready == 1, "R1 cmd_ready", cmd_ready, 1);
        check(rx_only == 1, "R1 rx_only", rx_only, 1);
        check(spi_valid == 0, "R1 spi_valid", spi_valid, 0);
        check(rsp_valid == 0, "R1 rsp_valid", rsp_valid, 0);

        // R6 refused while permit revoked from reset
        do_load(8'd5);
        do_send(1);
        // R2 window edges
        do_chan(8'(CMIN - 1));
        do_chan(8'(CMIN));
        do_chan(8'(CMAX + 1));
        do_chan(8'(CMAX));
        // R3 / R4 power corners
        do_power(8'd0);
        do_send(1);
        do_power(8'd1);
        do_power(8'(PMAX));
        do_power(8'd255);
        // R5 length corners
        do_load(8'd0);
        do_load(8'd1);
        do_load(8'd61);
        do_load(8'd62);
        do_load(8'd200);
        // R7 / R8
        do_send(1);
        do_send(0);

        // Random mix
        for (int k = 0; k < 60; k++) begin
            int sel;
            sel = $urandom(seed) % 4;
            case (sel)
                0: do_chan(8'($urandom(seed) % 48));
                1: do_power(8'($urandom(seed) % 14));
                2: do_load(8'($urandom(seed) % 80));
                default: do_send(($urandom(seed) % 4) != 0);
            endcase
        end
        finish_run();
    end
endmodule